// File: doc/BRIEF.md
# Multi-Mode Timer Channel

This block is a single general-purpose timer channel built around one external pin that takes on one of three roles. As a pulse generator it drives a periodic waveform whose period and high time are programmed. As a capture unit it measures the high time and the rise-to-rise period of a signal arriving on the pin. As an event counter it counts rising edges seen on the pin. A small register port sets the channel up, exposes the live count and the captured values, and holds two sticky flags that drive an interrupt output.

The counter advances on ticks. In pulse and capture modes a tick is either every system clock cycle or each rising edge of a shared timer clock input, chosen by a control bit. In event-counter mode a tick is each rising edge of the pin. Both external inputs pass through a two-stage synchronizer before edge detection. The pin is split into `tmr_pin_i`, `tmr_pin_o` and an output enable, so the pad itself stays outside.

The control state machine has five states: `ST_IDLE`, `ST_PWM_RUN`, `ST_CAP_ARM`, `ST_CAP_RUN` and `ST_EXT_RUN`. From `ST_IDLE`, setting the enable bit moves to `ST_PWM_RUN`, `ST_CAP_ARM` or `ST_EXT_RUN` according to the mode field (mode 3 stays in `ST_IDLE`). `ST_CAP_ARM` moves to `ST_CAP_RUN` on the first synchronized rising edge of the pin. Every run state returns to `ST_IDLE` when the enable bit clears or the mode field stops matching. Entering or leaving any state clears the counter.

Top module: `timer_channel`

Register map (3-bit address): 0 control, with bits [1:0] as the mode (0 pulse, 1 capture, 2 event counter, 3 none), bit 2 selecting the shared clock as the tick source, bit 3 as enable, and bit 4 as interrupt enable. 1 is the period. 2 is the high time. 3 is the live count, read-only. 4 is the status register: bit 0 is the event flag and bit 1 is the overflow flag, and writing 1 to a bit clears it. 5 is the captured period and 6 is the captured high time, both read-only. Reads are combinational.

## Requirements
- R1: After reset every register reads 0, and `tmr_pin_o`, `tmr_pin_oe` and `irq_o` are 0.
- R2: In pulse mode the counter runs from 0 to period−1 and wraps. `tmr_pin_oe` is 1. The pin is high for the first `width` ticks of each period, so any `period` consecutive system-clock cycles with every-cycle ticks hold exactly `width` high cycles.
- R3: In pulse mode a width of 0 keeps the pin low. A width at or above the period keeps it high.
- R4: The event flag (status bit 0) sets at every counter wrap in pulse and event-counter modes. It stays set until 1 is written to status bit 0. `irq_o` is the interrupt-enable bit ANDed with the OR of the two flags.
- R5: In capture mode the first rising edge after enable only arms the channel. Each later rising edge stores the number of ticks since the previous rising edge as the captured period. Each falling edge stores the number of ticks since the last rising edge as the captured high time.
- R6: Each capture, on a rising or falling edge in `ST_CAP_RUN`, sets the event flag.
- R7: In `ST_CAP_RUN`, a tick that wraps the counter past its maximum value without a rising edge sets the overflow flag (status bit 1).
- R8: In event-counter mode the count rises by one per rising edge on the pin. It wraps to 0 when it reaches the period, and that wrap sets the event flag.
- R9: With control bit 2 set, the pulse and capture modes tick on rising edges of `shared_tclk_i` instead of every cycle.
- R10: A pin rising edge is seen in the count on the third rising clock edge after the pin changes, because of the two synchronizer stages plus the edge register.
- R11: Clearing the enable bit returns the channel to `ST_IDLE` on the next clock edge. After that, `tmr_pin_oe` is 0 and the count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | CNT_W | Read data, combinational |
| tmr_pin_i | input | 1 | Pin level from the pad |
| tmr_pin_o | output | 1 | Pulse output to the pad |
| tmr_pin_oe | output | 1 | Pad output enable |
| shared_tclk_i | input | 1 | Shared timer clock input |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the period register does not change in the same cycle in which the count bound is checked, and that writes to clear the status arrive only through the normal write strobe. The stimulus reprograms the period and width only while the channel is disabled, or before the windows that are measured. The pin and shared clock are driven on falling clock edges and held for at least two cycles, so the synchronizer never sees a pulse too short to register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_PWM = 2'd0,
        MODE_CAP = 2'd1,
        MODE_EXT = 2'd2,
        MODE_OFF = 2'd3
    } tmr_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PWM_RUN = 3'd1,
        ST_CAP_ARM = 3'd2,
        ST_CAP_RUN = 3'd3,
        ST_EXT_RUN = 3'd4
    } tmr_state_e;

    typedef struct packed {
        logic      irq_en;
        logic      enable;
        logic      clk_sel;
        tmr_mode_e mode;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    localparam logic [2:0] ADDR_CTRL    = 3'd0;
    localparam logic [2:0] ADDR_PERIOD  = 3'd1;
    localparam logic [2:0] ADDR_WIDTH   = 3'd2;
    localparam logic [2:0] ADDR_COUNT   = 3'd3;
    localparam logic [2:0] ADDR_STATUS  = 3'd4;
    localparam logic [2:0] ADDR_CAP_PER = 3'd5;
    localparam logic [2:0] ADDR_CAP_WID = 3'd6;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] cap_per_i,
    input  logic [CNT_W-1:0] cap_wid_i,
    input  logic             evt_irq_i,
    input  logic             evt_ovf_i,
    output tmr_ctrl_t        ctrl_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] width_o,
    output logic             stat_irq_o,
    output logic             stat_ovf_o,
    output logic             irq_o
);
    localparam int CPAD = CNT_W - CTRL_W;
    localparam int SPAD = CNT_W - 2;

    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] width_q;
    logic             flag_irq_q;
    logic             flag_ovf_q;
    logic             clr_stat;

    assign clr_stat = wr_en && (wr_addr == ADDR_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            period_q <= '0;
            width_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL)   ctrl_q   <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_addr == ADDR_PERIOD) period_q <= wr_data;
            if (wr_addr == ADDR_WIDTH)  width_q  <= wr_data;
        end
    end

    // Setting wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_irq_q <= 1'b0;
            flag_ovf_q <= 1'b0;
        end else begin
            if (evt_irq_i)                    flag_irq_q <= 1'b1;
            else if (clr_stat && wr_data[0])  flag_irq_q <= 1'b0;
            if (evt_ovf_i)                    flag_ovf_q <= 1'b1;
            else if (clr_stat && wr_data[1])  flag_ovf_q <= 1'b0;
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_CTRL:    rd_data = {{CPAD{1'b0}}, ctrl_q};
            ADDR_PERIOD:  rd_data = period_q;
            ADDR_WIDTH:   rd_data = width_q;
            ADDR_COUNT:   rd_data = count_i;
            ADDR_STATUS:  rd_data = {{SPAD{1'b0}}, flag_ovf_q, flag_irq_q};
            ADDR_CAP_PER: rd_data = cap_per_i;
            ADDR_CAP_WID: rd_data = cap_wid_i;
            default:      rd_data = '0;
        endcase
    end

    assign ctrl_o     = ctrl_q;
    assign period_o   = period_q;
    assign width_o    = width_q;
    assign stat_irq_o = flag_irq_q;
    assign stat_ovf_o = flag_ovf_q;
    assign irq_o      = ctrl_q.irq_en && (flag_irq_q || flag_ovf_q);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_mode_e        mode_i,
    input  logic             enable_i,
    input  logic             clk_sel_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] width_i,
    input  logic             pin_lvl_i,
    input  logic             sh_lvl_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cap_per_o,
    output logic [CNT_W-1:0] cap_wid_o,
    output logic             evt_irq_o,
    output logic             evt_ovf_o,
    output logic             pwm_o,
    output logic             drive_o,
    output tmr_state_e       state_o,
    output logic             pin_rise_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W:0]   ONE_W   = {{CNT_W{1'b0}}, 1'b1};

    tmr_state_e       state_q, state_n;
    logic [CNT_W-1:0] count_q, cap_per_q, cap_wid_q, cnt_inc;
    logic             pin_prev_q, sh_prev_q;
    logic             pin_rise, pin_fall, sh_rise;
    logic             tick, period_end, leave;
    logic [CNT_W:0]   cnt_next_wide;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_prev_q <= 1'b0;
            sh_prev_q  <= 1'b0;
        end else begin
            pin_prev_q <= pin_lvl_i;
            sh_prev_q  <= sh_lvl_i;
        end
    end

    assign pin_rise = pin_lvl_i && !pin_prev_q;
    assign pin_fall = !pin_lvl_i && pin_prev_q;
    assign sh_rise  = sh_lvl_i && !sh_prev_q;

    always_comb begin
        unique case (state_q)
            ST_EXT_RUN: tick = pin_rise;
            default:    tick = clk_sel_i ? sh_rise : 1'b1;
        endcase
    end

    assign cnt_inc       = count_q + {{(CNT_W-1){1'b0}}, tick};
    assign cnt_next_wide = {1'b0, count_q} + ONE_W;
    assign period_end    = tick && (cnt_next_wide >= {1'b0, period_i});

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable_i) begin
                    unique case (mode_i)
                        MODE_PWM: state_n = ST_PWM_RUN;
                        MODE_CAP: state_n = ST_CAP_ARM;
                        MODE_EXT: state_n = ST_EXT_RUN;
                        default:  state_n = ST_IDLE;
                    endcase
                end
            end
            ST_PWM_RUN: if (!enable_i || mode_i != MODE_PWM) state_n = ST_IDLE;
            ST_CAP_ARM: begin
                if (!enable_i || mode_i != MODE_CAP) state_n = ST_IDLE;
                else if (pin_rise)                   state_n = ST_CAP_RUN;
            end
            ST_CAP_RUN: if (!enable_i || mode_i != MODE_CAP) state_n = ST_IDLE;
            ST_EXT_RUN: if (!enable_i || mode_i != MODE_EXT) state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    assign leave = (state_n != state_q);

    // Datapath registers driven per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            cap_per_q <= '0;
            cap_wid_q <= '0;
        end else begin
            unique case (state_q)
                ST_PWM_RUN, ST_EXT_RUN: begin
                    if (leave || period_end) count_q <= '0;
                    else                     count_q <= cnt_inc;
                end
                ST_CAP_RUN: begin
                    if (leave) begin
                        count_q <= '0;
                    end else if (pin_rise) begin
                        cap_per_q <= cnt_inc;
                        count_q   <= '0;
                    end else if (pin_fall) begin
                        cap_wid_q <= cnt_inc;
                        count_q   <= cnt_inc;
                    end else begin
                        count_q <= cnt_inc;
                    end
                end
                default: count_q <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        evt_irq_o = 1'b0;
        evt_ovf_o = 1'b0;
        drive_o   = 1'b0;
        unique case (state_q)
            ST_PWM_RUN: begin
                drive_o   = 1'b1;
                evt_irq_o = period_end;
            end
            ST_EXT_RUN: evt_irq_o = period_end;
            ST_CAP_RUN: begin
                evt_irq_o = pin_rise || pin_fall;
                evt_ovf_o = tick && (count_q == CNT_MAX) && !pin_rise;
            end
            default: ;
        endcase
    end

    assign pwm_o      = drive_o && (count_q < width_i);
    assign count_o    = count_q;
    assign cap_per_o  = cap_per_q;
    assign cap_wid_o  = cap_wid_q;
    assign state_o    = state_q;
    assign pin_rise_o = pin_rise;
endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             tmr_pin_i,
    output logic             tmr_pin_o,
    output logic             tmr_pin_oe,
    input  logic             shared_tclk_i,
    output logic             irq_o
);
    tmr_ctrl_t        ctrl_w;
    tmr_state_e       state_w;
    logic [CNT_W-1:0] period_w, width_w, count_w, cap_per_w, cap_wid_w;
    logic             evt_irq_w, evt_ovf_w, stat_irq_w, stat_ovf_w;
    logic             pin_lvl_w, sh_lvl_w, pin_rise_w;

    tmr_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .async_i(tmr_pin_i), .level_o(pin_lvl_w)
    );

    tmr_sync #(.STAGES(SYNC_STAGES)) u_sh_sync (
        .clk(clk), .rst_n(rst_n), .async_i(shared_tclk_i), .level_o(sh_lvl_w)
    );

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .count_i(count_w), .cap_per_i(cap_per_w), .cap_wid_i(cap_wid_w),
        .evt_irq_i(evt_irq_w), .evt_ovf_i(evt_ovf_w),
        .ctrl_o(ctrl_w), .period_o(period_w), .width_o(width_w),
        .stat_irq_o(stat_irq_w), .stat_ovf_o(stat_ovf_w), .irq_o(irq_o)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .mode_i(ctrl_w.mode), .enable_i(ctrl_w.enable), .clk_sel_i(ctrl_w.clk_sel),
        .period_i(period_w), .width_i(width_w),
        .pin_lvl_i(pin_lvl_w), .sh_lvl_i(sh_lvl_w),
        .count_o(count_w), .cap_per_o(cap_per_w), .cap_wid_o(cap_wid_w),
        .evt_irq_o(evt_irq_w), .evt_ovf_o(evt_ovf_w),
        .pwm_o(tmr_pin_o), .drive_o(tmr_pin_oe),
        .state_o(state_w), .pin_rise_o(pin_rise_w)
    );
endmodule

// File: rtl/timer_channel_chk.sv
module timer_channel_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             tmr_pin_o,
    input logic             tmr_pin_oe,
    input logic             ctrl_en,
    input tmr_state_e       state,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period,
    input logic             pin_rise,
    input logic             evt_ovf,
    input logic             stat_irq,
    input logic             stat_ovf
);
    AST_DRIVE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_pin_oe |-> $past(ctrl_en)); // R11

    AST_HIGH_ONLY_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_pin_o |-> tmr_pin_oe); // R2

    AST_PWM_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWM_RUN && $past(state == ST_PWM_RUN) && $stable(period))
        |-> (count < period || count == '0)); // R2

    AST_CAPTURE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAP_RUN && pin_rise) |=> (count == '0)); // R5

    AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ovf |=> stat_ovf); // R7

    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_irq && !(wr_en && wr_addr == ADDR_STATUS && wr_data[0])) |=> stat_irq); // R4
endmodule

bind timer_channel timer_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmr_pin_o(tmr_pin_o), .tmr_pin_oe(tmr_pin_oe),
    .ctrl_en(ctrl_w.enable), .state(state_w), .count(count_w),
    .period(period_w), .pin_rise(pin_rise_w), .evt_ovf(evt_ovf_w),
    .stat_irq(stat_irq_w), .stat_ovf(stat_ovf_w)
);

// File: tb/timer_channel_test.sv
module timer_channel_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic         pin_i = 1'b0;
    logic         pin_o, pin_oe, irq;
    logic         shclk = 1'b0;

    int checks = 0;
    int errors = 0;

    timer_channel #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .tmr_pin_i(pin_i), .tmr_pin_o(pin_o), .tmr_pin_oe(pin_oe),
        .shared_tclk_i(shclk), .irq_o(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic pulse(input int h, input int l);
        pin_i = 1'b1;
        repeat (h) @(negedge clk);
        pin_i = 1'b0;
        repeat (l) @(negedge clk);
    endtask

    task automatic high_cycles(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pin_o) hi++;
        end
    endtask

    task automatic t_reset();
        int v;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk("R1 register", v, 0);
        end
        chk("R1 pin_oe", int'(pin_oe), 0);
        chk("R1 pin_o", int'(pin_o), 0);
        chk("R1 irq", int'(irq), 0);
    endtask

    task automatic t_pwm();
        int hi, v;
        wr(3'd1, 10); wr(3'd2, 3); wr(3'd0, 24);
        repeat (4) @(negedge clk);
        high_cycles(10, hi);
        chk("R2 high cycles per period", hi, 3);
        chk("R2 pin_oe", int'(pin_oe), 1);
        rd(3'd4, v);
        chk("R4 event flag on wrap", v & 1, 1);
        chk("R4 irq out", int'(irq), 1);
    endtask

    task automatic t_disable();
        int v;
        wr(3'd0, 16);
        repeat (2) @(negedge clk);
        chk("R11 pin_oe after disable", int'(pin_oe), 0);
        rd(3'd3, v);
        chk("R11 count after disable", v, 0);
        repeat (15) @(negedge clk);
        rd(3'd4, v);
        chk("R4 flag sticky", v & 1, 1);
        wr(3'd4, 1);
        rd(3'd4, v);
        chk("R4 flag cleared", v & 1, 0);
        chk("R4 irq cleared", int'(irq), 0);
    endtask

    task automatic t_pwm_limits();
        int hi;
        wr(3'd1, 8); wr(3'd2, 0); wr(3'd0, 8);
        repeat (3) @(negedge clk);
        high_cycles(16, hi);
        chk("R3 width zero", hi, 0);
        wr(3'd2, 8);
        high_cycles(16, hi);
        chk("R3 width equals period", hi, 16);
        wr(3'd2, 20);
        high_cycles(16, hi);
        chk("R3 width above period", hi, 16);
        wr(3'd0, 0);
    endtask

    task automatic t_capture();
        int v;
        wr(3'd4, 3);
        wr(3'd0, 9);
        for (int k = 0; k < 3; k++) pulse(5, 7);
        repeat (6) @(negedge clk);
        rd(3'd5, v); chk("R5 captured period", v, 12);
        rd(3'd6, v); chk("R5 captured width", v, 5);
        rd(3'd4, v); chk("R6 capture sets flag", v & 1, 1);
        for (int k = 0; k < 3; k++) pulse(3, 2);
        repeat (6) @(negedge clk);
        rd(3'd5, v); chk("R5 captured period short", v, 5);
        rd(3'd6, v); chk("R5 captured width short", v, 3);
        wr(3'd0, 0);
    endtask

    task automatic t_overflow();
        int v;
        wr(3'd4, 3);
        wr(3'd0, 9);
        pulse(2, 100);
        rd(3'd4, v); chk("R7 no overflow yet", (v >> 1) & 1, 0);
        repeat (200) @(negedge clk);
        rd(3'd4, v); chk("R7 overflow flag", (v >> 1) & 1, 1);
        wr(3'd0, 0);
        wr(3'd4, 3);
    endtask

    task automatic t_extclk();
        int v;
        wr(3'd1, 100); wr(3'd0, 10);
        repeat (2) @(negedge clk);
        pin_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(3'd3, v); chk("R10 not yet counted", v, 0);
        @(negedge clk);
        rd(3'd3, v); chk("R10 counted on third edge", v, 1);
        pin_i = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 6; k++) pulse(2, 2);
        repeat (5) @(negedge clk);
        rd(3'd3, v); chk("R8 edge count", v, 7);
        wr(3'd0, 0); wr(3'd1, 4); wr(3'd4, 1); wr(3'd0, 10);
        for (int k = 0; k < 5; k++) pulse(2, 2);
        repeat (5) @(negedge clk);
        rd(3'd3, v); chk("R8 wrap count", v, 1);
        rd(3'd4, v); chk("R8 wrap flag", v & 1, 1);
        wr(3'd0, 0);
    endtask

    task automatic t_shared();
        int v;
        wr(3'd4, 3);
        wr(3'd0, 13);
        for (int i = 0; i < 130; i++) begin
            shclk = ((i % 4) < 2);
            pin_i = ((i % 40) < 20);
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rd(3'd5, v); chk("R9 shared clock period", v, 10);
        rd(3'd6, v); chk("R9 shared clock width", v, 5);
        wr(3'd0, 0);
        pin_i = 1'b0;
        shclk = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pwm();
        t_disable();
        t_pwm_limits();
        t_capture();
        t_overflow();
        t_extclk();
        t_shared();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule